// File: doc/BRIEF.md
# Palette Table Host Access Port

This block holds a 256-entry colour lookup table. A host reaches it through byte-wide I/O accesses at three addresses. Two of them load a pointer into the table, and the third carries colour bytes. One entry is red, green and blue, so it takes three consecutive data-port accesses. The pointer moves forward by itself once a full triple has been transferred, so a host can stream a whole run of entries after loading the pointer once.

There are two pointer ports, and they behave differently. The "read-mode" pointer port leaves a readable pointer one ahead of the entry actually addressed. The "write-mode" pointer port leaves the two equal. A hidden save register always selects the entry that the data port addresses, and it trails the visible index after a read-mode load. A separate pixel lookup port returns an entry one clock after it is given an index. This port works independently of host traffic.

When the internal table is switched off, the block drives active-low read and write strobes so that an external palette device can answer the same host accesses.

Top module: `palette_host_port`

## Requirements
- R1: After reset the index, save register, sequence step and mode are all zero. Reads of address 1 and address 0 return 8'h00, and both strobes are high.
- R2: A write of V to address 0 (read-mode pointer) sets the save register to V and the readable index to V+1. After it, reads of address 0 return 8'h03.
- R3: A write of V to address 1 (write-mode pointer) sets both the save register and the index to V. After it, reads of address 0 return 8'h00 and reads of address 1 return V.
- R4: Address 2 accesses cover red, then green, then blue of the entry selected by the save register. A red read latches the whole entry into a holding register. A blue write commits {red, green, blue} to the table in one cycle, using the red and green held from earlier in the triple.
- R5: Completing the third access of a triple increments both the save register and the index, wrapping from 8'hFF to 8'h00.
- R6: A write to address 0 or address 1 restarts the sequence at red.
- R7: Reads and writes at address 2 may be mixed within one triple, and each one advances the same sequence step.
- R8: With cfg_wide low (6-bit components), writes store only bits 5..0 of each byte, and data reads return bits 7..6 as zero.
- R9: With cfg_int_en low, ext_wr_n is low during a write to address 0, 1 or 2. With cfg_int_en low, ext_rd_n is low during a read of address 1 or 2, but not during a read of address 0. Address 3 asserts neither strobe and changes no state. With cfg_int_en high, both strobes stay high.
- R10: pix_rgb returns the entry at pix_idx as {red, green, blue} one clock after pix_idx is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_int_en | input | 1 | 1 = internal table in use, strobes held idle |
| cfg_wide | input | 1 | 1 = 8-bit components, 0 = 6-bit components |
| host_addr | input | 2 | 0 read-mode pointer, 1 write-mode pointer, 2 data, 3 unused |
| host_wr | input | 1 | Host write strobe for this cycle |
| host_rd | input | 1 | Host read strobe for this cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid during the read cycle |
| ext_rd_n | output | 1 | Active-low external palette read strobe |
| ext_wr_n | output | 1 | Active-low external palette write strobe |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Pixel lookup result {red, green, blue} |

## Verification
The hardest case to reach is a triple in which the data direction changes partway through. Here the red byte of the commit comes from the holding register, which a read filled, and not from a host write. The stimulus reads red, writes green and blue, and then checks through the pixel port that the committed entry combines the old red with the new green and blue. Reaching the wrap of both the save register and the index from 8'hFF also needs a pointer load at the top entry. This is done through each pointer port, followed by a full triple and a readback of the index.

// File: rtl/palette_host_port.sv
module palette_host_port #(
  parameter int IDX_W = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_int_en,
  input  logic                cfg_wide,
  input  logic [1:0]          host_addr,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [COMP_W-1:0]   host_wdata,
  output logic [COMP_W-1:0]   host_rdata,
  output logic                ext_rd_n,
  output logic                ext_wr_n,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = 3 * COMP_W;

  logic [ENT_W-1:0]  table_q [DEPTH];
  logic [IDX_W-1:0]  idx, save;
  logic [1:0]        seq;
  logic              rmode;
  logic [ENT_W-1:0]  hold;

  wire               ld_rm  = host_wr && host_addr == 2'd0;
  wire               ld_wm  = host_wr && host_addr == 2'd1;
  wire               dat    = (host_wr || host_rd) && host_addr == 2'd2;
  wire               dat_wr = dat && host_wr;
  wire               dat_rd = dat && !host_wr;
  wire               last   = dat && seq == 2'd2;
  wire [COMP_W-1:0]  mask   = cfg_wide ? {COMP_W{1'b1}} : {2'b00, {(COMP_W-2){1'b1}}};
  wire [COMP_W-1:0]  wbyte  = host_wdata & mask;
  wire [ENT_W-1:0]   cur    = table_q[save];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      save  <= '0;
      seq   <= '0;
      rmode <= 1'b0;
    end else if (ld_rm) begin
      save  <= host_wdata[IDX_W-1:0];
      idx   <= host_wdata[IDX_W-1:0] + 1'b1;
      seq   <= '0;
      rmode <= 1'b1;
    end else if (ld_wm) begin
      save  <= host_wdata[IDX_W-1:0];
      idx   <= host_wdata[IDX_W-1:0];
      seq   <= '0;
      rmode <= 1'b0;
    end else if (last) begin
      save  <= save + 1'b1;
      idx   <= idx + 1'b1;
      seq   <= '0;
    end else if (dat) begin
      seq   <= seq + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_rd && seq == 2'd0)
      hold <= cur;
    else if (dat_wr && seq == 2'd0)
      hold[ENT_W-1 -: COMP_W] <= wbyte;
    else if (dat_wr && seq == 2'd1)
      hold[2*COMP_W-1 -: COMP_W] <= wbyte;
  end

  always_ff @(posedge clk) begin
    if (dat_wr && seq == 2'd2)
      table_q[save] <= {hold[ENT_W-1 -: 2*COMP_W], wbyte};
    pix_rgb <= table_q[pix_idx];
  end

  logic [COMP_W-1:0] dbyte;
  always_comb begin
    case (seq)
      2'd0:    dbyte = cur[ENT_W-1 -: COMP_W];
      2'd1:    dbyte = hold[2*COMP_W-1 -: COMP_W];
      default: dbyte = hold[COMP_W-1:0];
    endcase
    case (host_addr)
      2'd0:    host_rdata = {{(COMP_W-2){1'b0}}, rmode, rmode};
      2'd1:    host_rdata = COMP_W'(idx);
      2'd2:    host_rdata = dbyte & mask;
      default: host_rdata = '0;
    endcase
  end

  assign ext_wr_n = !(host_wr && !cfg_int_en && host_addr != 2'd3);
  assign ext_rd_n = !(host_rd && !host_wr && !cfg_int_en &&
                      (host_addr == 2'd1 || host_addr == 2'd2));

  assert_strobes_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_int_en |-> (ext_rd_n && ext_wr_n));
  assert_seq_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq != 2'd3);
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rm || ld_wm) |=> seq == 2'd0);
  assert_trail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rm |=> idx == save + 1'b1);
  assert_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wm |=> idx == save);
  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (save == $past(save) + 1'b1) && (idx == $past(idx) + 1'b1));
endmodule

// File: tb/palette_host_port_tb.sv
module palette_host_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_int_en = 1'b1, cfg_wide = 1'b1;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        ext_rd_n, ext_wr_n;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #2 clk = ~clk;

  palette_host_port u_dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic [7:0] exp, input string req);
    @(negedge clk);
    host_wr = w; host_rd = !w; host_addr = a; host_wdata = d;
    if (!w) begin exp_q.push_back(exp); req_q.push_back(req); end
    #1;
    chk(ext_wr_n, !(w && !cfg_int_en && a != 2'd3), "R9 ext_wr_n");
    chk(ext_rd_n, !(!w && !cfg_int_en && (a == 2'd1 || a == 2'd2)), "R9 ext_rd_n");
    @(posedge clk); #1;
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    acc(1'b1, a, d, 8'h00, "");
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    acc(1'b0, a, 8'h00, exp, req);
  endtask

  task automatic pix(input logic [7:0] i, input logic [23:0] exp, input string req);
    @(negedge clk); pix_idx = i;
    @(posedge clk); #1;
    chk(pix_rgb, exp, req);
  endtask

  always @(negedge clk) begin
    #1;
    if (host_rd) begin
      if (exp_q.size() == 0) chk(1, 0, "scoreboard underflow");
      else chk(host_rdata, exp_q.pop_front(), req_q.pop_front());
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1; chk({ext_rd_n, ext_wr_n}, 2'b11, "R1 strobes in reset");
    #10 rst_n = 1'b1;
    rd(2'd1, 8'h00, "R1 index");
    rd(2'd0, 8'h00, "R1 mode");
    // R3 write-mode pointer
    wr(2'd1, 8'h10);
    rd(2'd1, 8'h10, "R3 index");
    rd(2'd0, 8'h00, "R3 mode");
    // R4 streaming writes, R5 auto-advance
    wr(2'd2, 8'h11); wr(2'd2, 8'h22); wr(2'd2, 8'h33);
    wr(2'd2, 8'h44); wr(2'd2, 8'h55); wr(2'd2, 8'h66);
    rd(2'd1, 8'h12, "R5 index after two triples");
    // R2 read-mode pointer
    wr(2'd0, 8'h10);
    rd(2'd0, 8'h03, "R2 mode");
    rd(2'd1, 8'h11, "R2 index ahead");
    rd(2'd2, 8'h11, "R4 red"); rd(2'd2, 8'h22, "R4 green"); rd(2'd2, 8'h33, "R4 blue");
    rd(2'd1, 8'h12, "R5 index");
    rd(2'd2, 8'h44, "R4 red"); rd(2'd2, 8'h55, "R4 green"); rd(2'd2, 8'h66, "R4 blue");
    rd(2'd1, 8'h13, "R5 index");
    // R10 pixel port
    pix(8'h10, 24'h112233, "R10 entry 10");
    pix(8'h11, 24'h445566, "R10 entry 11");
    // R6 restart
    wr(2'd1, 8'h10);
    rd(2'd2, 8'h11, "R6 red");
    wr(2'd1, 8'h10);
    rd(2'd2, 8'h11, "R6 restart red"); rd(2'd2, 8'h22, "R6 green"); rd(2'd2, 8'h33, "R6 blue");
    // R7 mixed triple
    wr(2'd1, 8'h11);
    rd(2'd2, 8'h44, "R7 red read");
    wr(2'd2, 8'h77); wr(2'd2, 8'h88);
    pix(8'h11, 24'h447788, "R7 mixed commit");
    rd(2'd1, 8'h12, "R7 index advanced");
    // R5 wrap
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01); wr(2'd2, 8'h02); wr(2'd2, 8'h03);
    rd(2'd1, 8'h00, "R5 wrap write-mode");
    wr(2'd0, 8'hFF);
    rd(2'd1, 8'h00, "R2 wrap index");
    rd(2'd2, 8'h01, "R5 red"); rd(2'd2, 8'h02, "R5 green"); rd(2'd2, 8'h03, "R5 blue");
    rd(2'd1, 8'h01, "R5 wrap read-mode");
    // R8 six-bit mode
    cfg_wide = 1'b0;
    wr(2'd1, 8'h30);
    wr(2'd2, 8'hFF); wr(2'd2, 8'hC5); wr(2'd2, 8'h80);
    pix(8'h30, 24'h3F0500, "R8 stored masked");
    wr(2'd1, 8'h11);
    rd(2'd2, 8'h04, "R8 red"); rd(2'd2, 8'h37, "R8 green"); rd(2'd2, 8'h08, "R8 blue");
    cfg_wide = 1'b1;
    // R9 external strobes (checked inside every access)
    cfg_int_en = 1'b0;
    wr(2'd1, 8'h40);
    rd(2'd0, 8'h00, "R9 mode read");
    rd(2'd1, 8'h40, "R9 index read");
    wr(2'd3, 8'h55);
    rd(2'd1, 8'h40, "R9 address 3 no effect");
    wr(2'd0, 8'h40);
    rd(2'd0, 8'h03, "R9 mode after read-mode load");
    cfg_int_en = 1'b1;
    wr(2'd1, 8'h10);
    rd(2'd2, 8'h11, "R9 enabled read");
    #20;
    chk(exp_q.size(), 0, "scoreboard drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule